// File: doc/BRIEF.md
# Eight-channel DMA controller

This block moves data between memory locations on behalf of eight independent channels. All of them share one memory-side bus that is gained by request and grant. A channel is set up through a write port with a source address, a destination address, a unit count, a unit size and mode bits. Once set up, the channel waits for a trigger. The trigger is the rising edge of either its external request pin or its peripheral interrupt line. Each transferred unit is a read from the source followed by a write of the captured data to the destination.

Each channel runs in one of two sequencing modes. In step mode one trigger moves a single unit. In block mode one trigger moves every remaining unit. Each channel also runs in one of two bus modes. In burst mode the bus is kept for the whole block. In continuous mode the bus is released after every unit, and the channels are re-arbitrated by fixed priority. A non-maskable or ordinary interrupt request stops new units from starting. Work resumes on its own once both requests are low. When a channel's count runs out, it disables itself and raises its completion flag.

Top module: `dma_ctrl8`

## Requirements
- R1: A cycle with cfg_we high loads channel cfg_ch. A nonzero cfg_cnt enables the channel and clears its done flag and any pending trigger. A zero cfg_cnt leaves the channel disabled, and its triggers then cause no bus activity.
- R2: With cfg_trig_sel=0 the channel is triggered by a rising edge on dreq[i]. With cfg_trig_sel=1 it is triggered by a rising edge on pirq[i]. Edges on the source that is not selected have no effect.
- R3: With cfg_block=0 (step), each trigger moves exactly one unit.
- R4: With cfg_block=1 (block), one trigger moves units until the count reaches zero.
- R5: When several channels are pending, the lowest channel index is served first. The choice is made every time the engine is idle, which is after each unit in continuous mode and at the end of a burst.
- R6: With cfg_burst=1 and block mode, bus_req stays high across all units of the block. With cfg_burst=0, bus_req goes low for at least one cycle after every unit.
- R7: Size code 0, 1 and 2 selects 1, 2 and 4 bytes, and the code is driven on bus_size. After each unit the source or destination address advances by that byte count if its increment bit is set; otherwise it stays fixed.
- R8: After the unit that brings the count to zero, the channel is disabled and done[i] goes high. done[i] stays high until the channel is written again, and further triggers move nothing.
- R9: While nmi or irq is high, no new unit starts. A unit already on the bus completes, and a burst gives up the bus. Pending work resumes once both are low.
- R10: A unit raises bus_req and waits for bus_gnt. It then holds a read (bus_we=0, bus_addr=source) until bus_ack. It then holds a write (bus_we=1, bus_addr=destination, bus_wdata=the data read) until bus_ack.
- R11: After reset, bus_req is low, all done flags are low and no channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Channel setup strobe |
| cfg_ch | input | 3 | Channel selected for setup |
| cfg_src | input | 32 | Initial source address |
| cfg_dst | input | 32 | Initial destination address |
| cfg_cnt | input | 16 | Unit count |
| cfg_size | input | 2 | Unit size code (0: 1 B, 1: 2 B, 2: 4 B) |
| cfg_block | input | 1 | 1: block sequencing, 0: step |
| cfg_burst | input | 1 | 1: burst bus use, 0: continuous |
| cfg_trig_sel | input | 1 | 0: dreq pin, 1: peripheral interrupt |
| cfg_src_inc | input | 1 | Advance the source address after each unit |
| cfg_dst_inc | input | 1 | Advance the destination address after each unit |
| dreq | input | 8 | External transfer request pins |
| pirq | input | 8 | Peripheral interrupt request lines |
| nmi | input | 1 | Non-maskable interrupt request, pauses transfers |
| irq | input | 1 | Interrupt request, pauses transfers |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | 32 | Bus address |
| bus_we | output | 1 | 1: write cycle, 0: read cycle |
| bus_size | output | 2 | Unit size code of the current cycle |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Cycle completion from the responder |
| done | output | 8 | Per-channel completion flags |

## Verification
The assertions check the following rules on every cycle:
- the arbiter grants at most one channel, and never one above a pending lower index;
- a read holds its address until acknowledged, and the following write carries exactly the data read;
- continuous mode drops the request after each unit;
- a halted idle engine stays idle;
- no unit is counted on a disabled channel, and the final unit sets the done flag and clears the enable.

Only the bench scenarios can show whole transfer orderings. Those are the address sequences over every size and increment combination, the count of request rises in burst against continuous use, the service order after a pause, the resumption of a burst interrupted by a non-maskable request, and the fact that the unselected trigger source and exhausted channels move nothing.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_REQ  = 2'd1,
    ENG_RD   = 2'd2,
    ENG_WR   = 2'd3
  } eng_st_t;

  // Byte count of one unit for a size code; code 3 behaves as a word.
  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] shf_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) shf_q <= '0;
    else           shf_q <= {shf_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = shf_q[STAGES-1];

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_block,
  input  logic          cfg_burst,
  input  logic          cfg_trig_sel,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic          ext_req,
  input  logic          per_irq,
  input  logic          unit_done,
  output logic          ready,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [1:0]    size,
  output logic          block,
  output logic          burst,
  output logic          last,
  output logic          done
);

  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    size_q, size_d;
  logic          block_q, block_d, burst_q, burst_d, sel_q, sel_d;
  logic          sinc_q, sinc_d, dinc_q, dinc_d;
  logic          en_q, en_d, pend_q, pend_d, done_q, done_d;
  logic          trig_q, trig_now, trig_rise, upd;
  logic [AW-1:0] step;

  assign trig_now  = sel_q ? per_irq : ext_req;
  assign trig_rise = trig_now & ~trig_q;
  assign step      = AW'(unit_bytes(size_q));
  assign upd       = cfg_we | unit_done | trig_rise;

  always_comb begin
    src_d   = src_q;   dst_d   = dst_q;   cnt_d  = cnt_q;
    size_d  = size_q;  block_d = block_q; burst_d = burst_q;
    sel_d   = sel_q;   sinc_d  = sinc_q;  dinc_d = dinc_q;
    en_d    = en_q;    pend_d  = pend_q;  done_d = done_q;
    if (cfg_we) begin
      src_d   = cfg_src;   dst_d   = cfg_dst;   cnt_d  = cfg_cnt;
      size_d  = cfg_size;  block_d = cfg_block; burst_d = cfg_burst;
      sel_d   = cfg_trig_sel;
      sinc_d  = cfg_src_inc;
      dinc_d  = cfg_dst_inc;
      en_d    = (cfg_cnt != '0);
      pend_d  = 1'b0;
      done_d  = 1'b0;
    end else begin
      if (unit_done) begin
        cnt_d = cnt_q - CW'(1);
        if (sinc_q) src_d = src_q + step;
        if (dinc_q) dst_d = dst_q + step;
        if (cnt_q == CW'(1)) begin
          en_d   = 1'b0;
          pend_d = 1'b0;
          done_d = 1'b1;
        end else if (!block_q) begin
          pend_d = 1'b0;
        end
      end
      if (trig_rise && en_d) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;   dst_q   <= '0;   cnt_q  <= '0;
      size_q  <= '0;   block_q <= 1'b0; burst_q <= 1'b0;
      sel_q   <= 1'b0; sinc_q  <= 1'b0; dinc_q <= 1'b0;
      en_q    <= 1'b0; pend_q  <= 1'b0; done_q <= 1'b0;
    end else if (upd) begin
      src_q   <= src_d;   dst_q   <= dst_d;   cnt_q  <= cnt_d;
      size_q  <= size_d;  block_q <= block_d; burst_q <= burst_d;
      sel_q   <= sel_d;   sinc_q  <= sinc_d;  dinc_q <= dinc_d;
      en_q    <= en_d;    pend_q  <= pend_d;  done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_now;
  end

  assign ready = en_q & pend_q;
  assign src   = src_q;
  assign dst   = dst_q;
  assign size  = size_q;
  assign block = block_q;
  assign burst = burst_q;
  assign last  = (cnt_q == CW'(1));
  assign done  = done_q;

  // R1
  unit_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> en_q);

  // R8
  final_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !cfg_we && cnt_q == CW'(1)) |=> (done_q && !en_q && !ready));

  // R7
  src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !cfg_we && !sinc_q) |=> $stable(src_q));

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);

  logic [N-1:0] gnt;

  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  assign any = |gnt;

  always_comb begin
    // R5
    arb_onehot_chk: assert ($onehot0(gnt));
    // R5
    arb_lowest_chk: assert (gnt == '0 ? req == '0 : (req & (gnt - N'(1))) == '0);
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          win_any,
  input  logic [IW-1:0] win_idx,
  input  logic [AW-1:0] src_sel,
  input  logic [AW-1:0] dst_sel,
  input  logic [1:0]    size_sel,
  input  logic          block_sel,
  input  logic          burst_sel,
  input  logic          last_sel,
  input  logic          bus_gnt,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic [IW-1:0] cur_idx,
  output logic [N-1:0]  unit_done,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata
);

  eng_st_t       st_q, st_d;
  logic [IW-1:0] cur_q, cur_d;
  logic [DW-1:0] buf_q, buf_d;
  logic          keep_bus;

  assign keep_bus = burst_sel & block_sel & ~last_sel & ~halt;

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    buf_d     = buf_q;
    unit_done = '0;
    case (st_q)
      ENG_IDLE: if (!halt && win_any) begin
        cur_d = win_idx;
        st_d  = ENG_REQ;
      end
      ENG_REQ:  if (bus_gnt) st_d = ENG_RD;
      ENG_RD:   if (bus_ack) begin
        buf_d = bus_rdata;
        st_d  = ENG_WR;
      end
      ENG_WR:   if (bus_ack) begin
        unit_done[cur_q] = 1'b1;
        st_d = keep_bus ? ENG_RD : ENG_IDLE;
      end
      default:  st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      cur_q <= '0;
      buf_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      if (st_q == ENG_RD && bus_ack) buf_q <= buf_d;
    end
  end

  assign cur_idx   = cur_q;
  assign bus_req   = (st_q != ENG_IDLE);
  assign bus_we    = (st_q == ENG_WR);
  assign bus_addr  = (st_q == ENG_WR) ? dst_sel : src_sel;
  assign bus_size  = size_sel;
  assign bus_wdata = buf_q;

  // R9
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_IDLE && halt) |=> (st_q == ENG_IDLE));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_RD && !bus_ack) |=> (st_q == ENG_RD && $stable(bus_addr)));

  // R10
  wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_RD && bus_ack) |=> (bus_we && bus_wdata == $past(bus_rdata)));

  // R6
  cont_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_WR && bus_ack && !burst_sel) |=> !bus_req);

endmodule

// File: rtl/dma_ctrl8.sv
module dma_ctrl8 #(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_cnt,
  input  logic [1:0]     cfg_size,
  input  logic           cfg_block,
  input  logic           cfg_burst,
  input  logic           cfg_trig_sel,
  input  logic           cfg_src_inc,
  input  logic           cfg_dst_inc,
  input  logic [NCH-1:0] dreq,
  input  logic [NCH-1:0] pirq,
  input  logic           nmi,
  input  logic           irq,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_we,
  output logic [1:0]     bus_size,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_ack,
  output logic [NCH-1:0] done
);

  logic           rst_n_s;
  logic [NCH-1:0] ready_v, block_v, burst_v, last_v, udone_v;
  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  logic [1:0]     size_a [NCH];
  logic [CHW-1:0] win_idx, cur_idx;
  logic           win_any;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan #(.AW(AW), .CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n_s),
      .cfg_we(cfg_we && cfg_ch == CHW'(g)),
      .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
      .cfg_size(cfg_size), .cfg_block(cfg_block), .cfg_burst(cfg_burst),
      .cfg_trig_sel(cfg_trig_sel), .cfg_src_inc(cfg_src_inc),
      .cfg_dst_inc(cfg_dst_inc),
      .ext_req(dreq[g]), .per_irq(pirq[g]), .unit_done(udone_v[g]),
      .ready(ready_v[g]), .src(src_a[g]), .dst(dst_a[g]), .size(size_a[g]),
      .block(block_v[g]), .burst(burst_v[g]), .last(last_v[g]), .done(done[g])
    );
  end

  dma_arb #(.N(NCH), .IW(CHW)) u_arb (
    .req(ready_v), .idx(win_idx), .any(win_any)
  );

  dma_engine #(.N(NCH), .AW(AW), .DW(DW), .IW(CHW)) u_eng (
    .clk(clk), .rst_n(rst_n_s), .halt(nmi | irq),
    .win_any(win_any), .win_idx(win_idx),
    .src_sel(src_a[cur_idx]), .dst_sel(dst_a[cur_idx]),
    .size_sel(size_a[cur_idx]), .block_sel(block_v[cur_idx]),
    .burst_sel(burst_v[cur_idx]), .last_sel(last_v[cur_idx]),
    .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .cur_idx(cur_idx), .unit_done(udone_v),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_size(bus_size), .bus_wdata(bus_wdata)
  );

endmodule

// File: tb/tb_dma_ctrl8.sv
module tb_dma_ctrl8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_ch = '0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_cnt = '0;
  logic [1:0]  cfg_size = '0;
  logic        cfg_block = 1'b0, cfg_burst = 1'b0, cfg_trig_sel = 1'b0;
  logic        cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0;
  logic [7:0]  dreq = '0, pirq = '0;
  logic        nmi = 1'b0, irq = 1'b0;
  logic        bus_req, bus_we, bus_gnt, bus_ack;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic [7:0]  done;

  always #5 clk = ~clk;

  dma_ctrl8 dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .cfg_size(cfg_size), .cfg_block(cfg_block), .cfg_burst(cfg_burst),
    .cfg_trig_sel(cfg_trig_sel), .cfg_src_inc(cfg_src_inc),
    .cfg_dst_inc(cfg_dst_inc), .dreq(dreq), .pirq(pirq), .nmi(nmi), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .done(done)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h5A5A_0000;
  endfunction

  // Responder: grant follows request, acknowledge every other granted cycle.
  assign bus_rdata = memf(bus_addr);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0;
      bus_ack <= 1'b0;
    end else begin
      bus_gnt <= bus_req;
      bus_ack <= bus_req && bus_gnt && !bus_ack;
    end
  end

  // Monitor, away from the active edge.
  logic [31:0] log_addr [0:511];
  logic        log_we   [0:511];
  logic [1:0]  log_sz   [0:511];
  int          log_n = 0, req_rises = 0, wr_bad = 0;
  logic        req_prev = 1'b0;
  logic [31:0] last_rd_addr = '0;

  always @(negedge clk) begin
    if (bus_req && !req_prev) req_rises++;
    req_prev = bus_req;
    if (bus_req && bus_ack && log_n < 512) begin
      log_addr[log_n] = bus_addr;
      log_we[log_n]   = bus_we;
      log_sz[log_n]   = bus_size;
      if (!bus_we) last_rd_addr = bus_addr;
      else if (bus_wdata != memf(last_rd_addr)) wr_bad++;
      log_n++;
    end
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int ch, input logic [31:0] s, input logic [31:0] d,
                     input logic [15:0] n, input logic [1:0] sz, input logic blk,
                     input logic bst, input logic sel, input logic si, input logic di);
    @(negedge clk);
    cfg_ch = 3'(ch); cfg_src = s; cfg_dst = d; cfg_cnt = n; cfg_size = sz;
    cfg_block = blk; cfg_burst = bst; cfg_trig_sel = sel;
    cfg_src_inc = si; cfg_dst_inc = di; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_ext(input int ch);
    @(negedge clk) dreq[ch] = 1'b1;
    @(negedge clk) dreq[ch] = 1'b0;
  endtask

  task automatic pulse_per(input int ch);
    @(negedge clk) pirq[ch] = 1'b1;
    @(negedge clk) pirq[ch] = 1'b0;
  endtask

  task automatic check_units(input int base, input int n, input logic [31:0] s0,
                             input logic [31:0] d0, input int ss, input int ds,
                             input string tag);
    for (int k = 0; k < n; k++) begin
      chk(tag, log_addr[base + 2*k],     s0 + 32'(k * ss));
      chk(tag, 32'(log_we[base + 2*k]),   32'd0);
      chk(tag, log_addr[base + 2*k + 1], d0 + 32'(k * ds));
      chk(tag, 32'(log_we[base + 2*k + 1]), 32'd1);
    end
  endtask

  task automatic run_all();
    int base, r0, got;
    // R11 reset state
    settle(3);
    chk("R11 bus_req", 32'(bus_req), 32'd0);
    chk("R11 done", 32'(done), 32'd0);
    rst_n = 1'b1;
    settle(5);
    chk("R11 idle after release", 32'(bus_req), 32'd0);

    // R1 zero count leaves channel disabled
    base = log_n;
    cfg(7, 32'h7000, 32'h7100, 16'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    pulse_ext(7);
    settle(30);
    chk("R1 zero count no traffic", 32'(log_n - base), 32'd0);
    chk("R1 zero count no done", 32'(done[7]), 32'd0);

    // R3 step, R2 source select, R8 completion
    base = log_n;
    cfg(2, 32'h100, 32'h200, 16'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    pulse_ext(2);
    settle(30);
    chk("R3 one unit per trigger", 32'(log_n - base), 32'd2);
    chk("R3 not done yet", 32'(done[2]), 32'd0);
    pulse_per(2);
    settle(30);
    chk("R2 unselected source ignored", 32'(log_n - base), 32'd2);
    pulse_ext(2);
    settle(30);
    pulse_ext(2);
    settle(30);
    chk("R3 three triggers three units", 32'(log_n - base), 32'd6);
    check_units(base, 3, 32'h100, 32'h200, 4, 4, "R10 step addresses");
    chk("R8 done after last unit", 32'(done[2]), 32'd1);
    pulse_ext(2);
    settle(30);
    chk("R8 exhausted channel idle", 32'(log_n - base), 32'd6);
    chk("R8 done held", 32'(done[2]), 32'd1);

    // R7/R4 sweep over size codes and increment combinations
    for (int sz = 0; sz < 3; sz++) begin
      for (int inc = 0; inc < 4; inc++) begin
        int nb = 1 << sz;
        base = log_n;
        cfg(1, 32'h1000, 32'h2000, 16'd3, 2'(sz), 1'b1, 1'b1, 1'b1, inc[0], inc[1]);
        chk("R1 config clears done", 32'(done[1]), 32'd0);
        pulse_per(1);
        settle(60);
        chk("R4 block moves all units", 32'(log_n - base), 32'd6);
        check_units(base, 3, 32'h1000, 32'h2000, inc[0] ? nb : 0, inc[1] ? nb : 0,
                    "R7 address step");
        chk("R7 bus_size code", 32'(log_sz[base]), 32'(sz));
        chk("R8 block done", 32'(done[1]), 32'd1);
      end
    end

    // R6 burst versus continuous
    r0 = req_rises;
    cfg(4, 32'h4000, 32'h4400, 16'd4, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    pulse_ext(4);
    settle(60);
    chk("R6 burst single request", 32'(req_rises - r0), 32'd1);
    r0 = req_rises;
    cfg(4, 32'h4000, 32'h4400, 16'd4, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    pulse_ext(4);
    settle(80);
    chk("R6 continuous request per unit", 32'(req_rises - r0), 32'd4);

    // R9 pause, R5 priority order on release
    base = log_n;
    irq = 1'b1;
    cfg(6, 32'h6000, 32'h6800, 16'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    cfg(3, 32'h3000, 32'h3800, 16'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk) begin dreq[3] = 1'b1; dreq[6] = 1'b1; end
    @(negedge clk) begin dreq[3] = 1'b0; dreq[6] = 1'b0; end
    settle(40);
    chk("R9 irq blocks start", 32'(log_n - base), 32'd0);
    chk("R9 no request while halted", 32'(bus_req), 32'd0);
    irq = 1'b0;
    settle(80);
    chk("R5 all units moved", 32'(log_n - base), 32'd8);
    check_units(base, 2, 32'h3000, 32'h3800, 4, 4, "R5 lower channel first");
    check_units(base + 4, 2, 32'h6000, 32'h6800, 4, 4, "R5 higher channel after");

    // R9 non-maskable request during a burst
    base = log_n;
    cfg(5, 32'h5000, 32'h5400, 16'd6, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    pulse_ext(5);
    for (int w = 0; w < 200 && log_n < base + 2; w++) @(negedge clk);
    nmi = 1'b1;
    settle(40);
    got = log_n - base;
    chk("R9 burst paused on unit boundary", 32'(got < 12 && got % 2 == 0), 32'd1);
    chk("R9 bus released", 32'(bus_req), 32'd0);
    nmi = 1'b0;
    settle(100);
    chk("R9 burst resumes", 32'(log_n - base), 32'd12);
    check_units(base, 6, 32'h5000, 32'h5400, 2, 2, "R9 resumed addresses");
    chk("R8 done after resume", 32'(done[5]), 32'd1);

    chk("R10 write data equals read data", 32'(wr_bad), 32'd0);
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    if (wd) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule